// File: doc/BRIEF.md
# Three-Moduli Residue-to-Binary Converter

This block turns a number held as three residues back into its plain binary form. The moduli are 2^m−1, 2^m+1 and 2^(2m)+1, where m is a parameter. Their product, 2^(4m)−1, sets the dynamic range. The inputs are an m-bit residue, an (m+1)-bit residue and a (2m+1)-bit residue. The result is a 4m-bit word in the range 0 to 2^(4m)−2.

The datapath uses no multipliers. From the residues it builds five 4m-bit terms using only rotation, bit complement and constant fill. Three carry-save stages with end-around carry reduce the five terms to a sum/carry pair. A final adder modulo 2^(4m)−1 adds that pair. The adder is built in one of two styles, chosen by a parameter.

A single output register, cleared by a synchronous active-low reset, holds the result. Each conversion therefore takes one clock cycle.

Top module: `rb3_converter`

## Requirements
- R1: If rst_n is low at a rising clock edge, bin_out becomes zero at that edge. In the first cycle after reset is released, bin_out still reads zero.
- R2: If rst_n is high at a rising edge, bin_out loads the unique value X in [0, 2^(4m)−2] that satisfies all three of these: X mod (2^m−1) equals res_a, X mod (2^m+1) equals res_b, and X mod (2^(2m)+1) equals res_c. The residues used are the ones present at that edge.
- R3: bin_out is never the all-ones word.
- R4: When all three residues are zero, the modular sum comes out as the all-ones word, and that word is folded to zero. bin_out therefore reads 0.
- R5: The residues of 2^(4m)−2 (for m=2: 2, 4, 16) convert to 2^(4m)−2, which is the top of the range (254 for m=2).
- R6: For m=2 (moduli 3, 5 and 17), the residues (2, 1, 11) convert to 11.
- R7: The two final-adder styles give identical bin_out for every valid residue triple. ADD_STYLE 0 wraps the carry and then folds all-ones; ADD_STYLE 1 selects between the sum and the sum plus one.
- R8: bin_out changes only at a rising edge. If the residues change between edges, bin_out keeps its value until the next edge. While the residues stay constant, bin_out stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bin_out is registered on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| res_a | input | M | Residue modulo 2^M−1 |
| res_b | input | M+1 | Residue modulo 2^M+1 |
| res_c | input | 2M+1 | Residue modulo 2^(2M)+1 |
| bin_out | output | 4M | Binary result in [0, 2^(4M)−2] |

## Verification
Two functions of the final adder can act in the same cycle: the end-around wrap of its carry-out and the fold of an all-ones sum to zero. The zero residue triple makes the sum land exactly on the all-ones word, so the fold is needed there. Residue triples near the top of the range push the sum past the word width, so the wrap is needed there. The bench covers both cases and checks that neither adder style lets the other correction produce a wrong result. Separately, the bench asserts reset while nonzero residues are applied. It then confirms that the register shows zero, and that the converted value appears one cycle after release.

// File: rtl/rb3_pkg.sv
// Shared definitions for the three-moduli residue-to-binary converter.
// Assumes: nothing beyond a parameter M >= 2 chosen by the user.
package rb3_pkg;

    // Selects how the final modulo 2^W-1 addition is built.
    typedef enum int {
        ADD_WRAP_FOLD   = 0,  // add, re-add carry-out, map all-ones to zero
        ADD_DUAL_SELECT = 1   // form s+c and s+c+1, pick by carry of the latter
    } add_style_e;

    // Number of terms summed modulo 2^(4m)-1.
    localparam int NUM_TERMS = 5;

    // Word width derived from the modulus parameter m.
    function automatic int word_width(input int m);
        return 4 * m;
    endfunction

endpackage

// File: rtl/rb3_operand_gen.sv
// Builds the five 4M-bit terms whose sum modulo 2^(4M)-1 is the binary value.
// Each term is a weighted residue reduced by rotation, complement and fill;
// no arithmetic is performed here.
// Assumes: M >= 2; residues are in range (not checked).
module rb3_operand_gen #(
    parameter int M = 4,
    localparam int W = rb3_pkg::word_width(M)
) (
    input  logic [M-1:0]   res_a,
    input  logic [M:0]     res_b,
    input  logic [2*M:0]   res_c,
    output logic [W-1:0]   term [rb3_pkg::NUM_TERMS]
);

    logic [W-1:0] a_rep;   // res_a repeated four times
    logic [W-1:0] b_wide;  // res_b zero-extended
    logic [W-1:0] b_pair;  // res_b placed at bit 0 and bit 2M
    logic [W-1:0] c_wide;  // res_c zero-extended

    // Spread the residues into word-wide helper vectors.
    always_comb begin
        a_rep  = {4{res_a}};
        b_wide = W'(res_b);
        c_wide = W'(res_c);
        b_pair = b_wide | (b_wide << (2 * M));
    end

    // Form the five terms by rotation, complement and constant fill.
    always_comb begin
        // term from res_a: four copies rotated right by two
        term[0] = (a_rep >> 2) | (a_rep << (W - 2));
        // positive part of res_b: two zero-padded copies rotated right by two
        term[1] = (b_pair >> 2) | (b_pair << (W - 2));
        // negative part of res_b: complemented copies in a field of ones
        term[2] = ~((b_wide << (M - 2)) | (b_wide << (3 * M - 2)));
        // positive part of res_c: rotated right by one
        term[3] = (c_wide >> 1) | (c_wide << (W - 1));
        // negative part of res_c: complement on top of 2M-1 ones
        term[4] = ~(c_wide << (2 * M - 1));
    end

endmodule

// File: rtl/rb3_csa_eac.sv
// One carry-save stage modulo 2^W-1: three words in, sum and carry out.
// The carry word is rotated left one place so the top carry re-enters at bit 0.
// Assumes: W >= 2.
module rb3_csa_eac #(
    parameter int W = 16
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);

    logic [W-1:0] gen;

    // One full adder per bit position.
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit sum and majority carry.
        always_comb begin
            sum_o[i] = in_x[i] ^ in_y[i] ^ in_z[i];
            gen[i]   = (in_x[i] & in_y[i]) | (in_x[i] & in_z[i]) | (in_y[i] & in_z[i]);
        end
    end

    // End-around rotation of the carry word.
    always_comb carry_o = {gen[W-2:0], gen[W-1]};

endmodule

// File: rtl/rb3_modadd.sv
// Adds two W-bit words modulo 2^W-1 and returns the canonical result in
// [0, 2^W-2]. STYLE picks the construction; both give the same value.
// Assumes: inputs are any W-bit words.
module rb3_modadd #(
    parameter int W = 16,
    parameter rb3_pkg::add_style_e STYLE = rb3_pkg::ADD_WRAP_FOLD
) (
    input  logic [W-1:0] op_s,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] result
);

    if (STYLE == rb3_pkg::ADD_WRAP_FOLD) begin : g_wrap
        logic [W:0]   raw;
        logic [W-1:0] wrapped;
        // Add, re-add the carry-out, then fold the all-ones code to zero.
        always_comb begin
            raw     = {1'b0, op_s} + {1'b0, op_c};
            wrapped = raw[W-1:0] + W'(raw[W]);
            result  = (&wrapped) ? '0 : wrapped;
        end
    end else begin : g_select
        logic [W:0] plain;
        logic [W:0] plus1;
        // A carry out of s+c+1 means s+c >= 2^W-1, so s+c+1-2^W is the answer.
        always_comb begin
            plain  = {1'b0, op_s} + {1'b0, op_c};
            plus1  = plain + {{W{1'b0}}, 1'b1};
            result = plus1[W] ? plus1[W-1:0] : plain[W-1:0];
        end
    end

endmodule

// File: rtl/rb3_converter.sv
// Residue-to-binary converter for moduli 2^M-1, 2^M+1, 2^(2M)+1.
// Terms are reduced by a chain of end-around-carry CSA stages and a final
// modulo adder; the result is registered once (synchronous active-low reset).
// Assumes: residues in range; M >= 2.
module rb3_converter #(
    parameter int M = 4,
    parameter rb3_pkg::add_style_e ADD_STYLE = rb3_pkg::ADD_WRAP_FOLD,
    localparam int W = rb3_pkg::word_width(M)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M-1:0]   res_a,
    input  logic [M:0]     res_b,
    input  logic [2*M:0]   res_c,
    output logic [W-1:0]   bin_out
);

    localparam int NSTAGE = rb3_pkg::NUM_TERMS - 2;

    logic [W-1:0] term   [rb3_pkg::NUM_TERMS];
    logic [W-1:0] acc_s  [NSTAGE + 1];
    logic [W-1:0] acc_c  [NSTAGE + 1];
    logic [W-1:0] mod_sum;

    rb3_operand_gen #(.M(M)) u_terms (
        .res_a (res_a),
        .res_b (res_b),
        .res_c (res_c),
        .term  (term)
    );

    // Seed the carry-save chain with the first two terms.
    always_comb begin
        acc_s[0] = term[0];
        acc_c[0] = term[1];
    end

    // Each stage folds one further term into the running sum/carry pair.
    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        rb3_csa_eac #(.W(W)) u_csa (
            .in_x    (acc_s[g]),
            .in_y    (acc_c[g]),
            .in_z    (term[g + 2]),
            .sum_o   (acc_s[g + 1]),
            .carry_o (acc_c[g + 1])
        );
    end

    rb3_modadd #(.W(W), .STYLE(ADD_STYLE)) u_final (
        .op_s   (acc_s[NSTAGE]),
        .op_c   (acc_c[NSTAGE]),
        .result (mod_sum)
    );

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) bin_out <= '0;
        else        bin_out <= mod_sum;
    end

endmodule

// File: rtl/rb3_converter_chk.sv
// Property checker for rb3_converter; attached by bind below.
// Assumes: residues driven are in range.
module rb3_converter_chk #(
    parameter int M = 4,
    localparam int W = 4 * M
) (
    input logic           clk,
    input logic           rst_n,
    input logic [M-1:0]   res_a,
    input logic [M:0]     res_b,
    input logic [2*M:0]   res_c,
    input logic [W-1:0]   bin_out
);

    localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MOD_A = (ONE << M) - ONE;
    localparam logic [W-1:0] MOD_B = (ONE << M) + ONE;
    localparam logic [W-1:0] MOD_C = (ONE << (2 * M)) + ONE;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> bin_out == '0);

    // R2
    residue_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bin_out % MOD_A) == (W'($past(res_a)) % MOD_A));

    // R2
    residue_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bin_out % MOD_B) == (W'($past(res_b)) % MOD_B));

    // R2
    residue_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bin_out % MOD_C) == (W'($past(res_c)) % MOD_C));

    // R3
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&bin_out));

    // R4
    zero_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_a) == '0 && $past(res_b) == '0 && $past(res_c) == '0)
        |-> bin_out == '0);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(res_a) && $stable(res_b) && $stable(res_c))
        |=> $stable(bin_out));

endmodule

bind rb3_converter rb3_converter_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .res_a   (res_a),
    .res_b   (res_b),
    .res_c   (res_c),
    .bin_out (bin_out)
);

// File: tb/rb3_converter_bench.sv
// Bench for rb3_converter at M=2 (moduli 3, 5, 17), both adder styles.
module rb3_converter_bench;

    localparam int M = 2;
    localparam int W = 4 * M;
    localparam int NVEC = 12;
    localparam int TOP = (1 << W) - 2;

    // Vector: {res_a[2], res_b[3], res_c[5], expected[8]}
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd2, 3'd1, 5'd11, 8'd11},
        {2'd0, 3'd0, 5'd0,  8'd0},
        {2'd2, 3'd4, 5'd16, 8'd254},
        {2'd1, 3'd1, 5'd1,  8'd1},
        {2'd0, 3'd3, 5'd3,  8'd3},
        {2'd2, 3'd2, 5'd0,  8'd17},
        {2'd0, 3'd0, 5'd15, 8'd15},
        {2'd2, 3'd3, 5'd9,  8'd128},
        {2'd1, 3'd0, 5'd0,  8'd85},
        {2'd0, 3'd1, 5'd0,  8'd51},
        {2'd2, 3'd0, 5'd0,  8'd170},
        {2'd1, 3'd3, 5'd15, 8'd253}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [M-1:0]   res_a = '0;
    logic [M:0]     res_b = '0;
    logic [2*M:0]   res_c = '0;
    logic [W-1:0]   out_wrap;
    logic [W-1:0]   out_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    rb3_converter #(.M(M), .ADD_STYLE(rb3_pkg::ADD_WRAP_FOLD)) u_rb3_converter (
        .clk (clk), .rst_n (rst_n), .res_a (res_a), .res_b (res_b),
        .res_c (res_c), .bin_out (out_wrap)
    );

    rb3_converter #(.M(M), .ADD_STYLE(rb3_pkg::ADD_DUAL_SELECT)) u_rb3_converter_sel (
        .clk (clk), .rst_n (rst_n), .res_a (res_a), .res_b (res_b),
        .res_c (res_c), .bin_out (out_sel)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Apply residues at a falling edge; sample one falling edge later.
    task automatic convert(input int x);
        @(negedge clk);
        res_a = M'(x % 3);
        res_b = (M+1)'(x % 5);
        res_c = (2*M+1)'(x % 17);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 reset", out_wrap, '0);
        check("R1 reset sel", out_sel, '0);
        rst_n = 1'b1;

        // Table walk (R6 first entry, R4 zero fold, R5 top of range)
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {res_a, res_b, res_c} = VEC[i][17:8];
            @(negedge clk);
            check("R2 table R6 R4 R5", out_wrap, VEC[i][7:0]);
            check("R7 table select style", out_sel, VEC[i][7:0]);
        end

        // R2, R3, R7: exhaustive over the range
        for (int x = 0; x <= TOP; x++) begin
            convert(x);
            check("R2 exhaustive", out_wrap, W'(x));
            check("R7 exhaustive select", out_sel, W'(x));
            if (&out_wrap) check("R3 all-ones", out_wrap, '0);
        end

        // R4 directed: zero residues fold to zero
        convert(0);
        check("R4 zero fold", out_wrap, '0);
        check("R4 zero fold sel", out_sel, '0);

        // R5 directed: top of range
        convert(TOP);
        check("R5 top", out_wrap, W'(TOP));

        // R8: mid-cycle input change does not reach the output before the edge
        convert(11);
        check("R6 directed", out_wrap, 8'd11);
        res_a = 2'd2; res_b = 3'd0; res_c = 5'd13;  // residues of 200
        #2;
        check("R8 hold before edge", out_wrap, 8'd11);
        @(negedge clk);
        check("R8 update after edge", out_wrap, 8'd200);
        @(negedge clk);
        check("R8 stable inputs", out_wrap, 8'd200);

        // R1: reset with nonzero residues applied, then release
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", out_wrap, '0);
        check("R1 reset mid-run sel", out_sel, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 release converts", out_wrap, 8'd200);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule